// File: doc/BRIEF.md
# Frame Alignment and Loss-of-Frame Monitor

This block sits behind the byte aligner of a SONET STS-1/STS-3c receiver. It gets one strobe per received frame, together with a flag that says whether the framing bytes of that frame matched. It also gets the 8 kHz frame tick. From these inputs it keeps an out-of-frame (OOF) status with hysteresis. Declaring OOF takes several consecutive bad frames. While OOF, clearing it takes a short run of good frames.

Two timers advance on the frame tick. The OOF timer integrates the time spent out of frame. A brief return to alignment pauses it but does not clear it. The timer is zeroed only after alignment has held without a break for the full interval. The in-frame timer measures that unbroken aligned time. Loss of frame (LOF) is raised when the integrated OOF time reaches the limit. It drops when the in-frame timer reaches the limit. A one-clock pulse marks every change of OOF or LOF and can serve as an interrupt source.

With the default parameters, the limit is 24 frame ticks (3 ms), OOF needs 4 bad frames, and a return to alignment needs 2 good frames.

Top module: `frm_lof_mon`

## Requirements
- R1: After reset, `oof_o` is 1, `lof_o` is 0 and both timers are zero.
- R2: While out of frame, two consecutive strobes with `frame_ok_i`=1 clear `oof_o` one clock after the second strobe.
- R3: While out of frame, a bad frame restarts the good-frame run: the sequence good, bad, good leaves `oof_o` at 1.
- R4: While in frame, `oof_o` is set one clock after the fourth consecutive strobe with `frame_ok_i`=0. Three bad frames followed by a good one leave it at 0. A good frame never sets `oof_o`.
- R5: On each tick while `oof_o`=1, the OOF timer advances and saturates at 24. `lof_o` is set at the tick on which this timer reaches 24, and the count is kept across short in-frame periods.
- R6: The OOF timer is reset only at the tick on which the in-frame timer reaches 24. The in-frame timer counts ticks while `oof_o`=0, saturates at 24, and is zeroed by any tick with `oof_o`=1.
- R7: An asserted `lof_o` clears at the tick on which the in-frame timer reaches 24.
- R8: `status_chg_o` pulses high for exactly one clock, in the clock after each change of `oof_o` or of `lof_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb_i | input | 1 | One-clock strobe per received frame |
| frame_ok_i | input | 1 | Framing pattern of this frame was correct (valid with strobe) |
| tick_i | input | 1 | One-clock 8 kHz frame-period tick |
| oof_o | output | 1 | Out-of-frame status |
| lof_o | output | 1 | Loss-of-frame defect |
| status_chg_o | output | 1 | One-clock pulse after any change of OOF or LOF |

## Verification
The timers cannot be seen directly, so any fault in them shows up only as LOF being raised or cleared at the wrong tick. The bench therefore runs mixed sequences of OOF bursts and short aligned gaps. An OOF timer that is wrongly cleared would delay LOF by a whole burst. A timer that fails to saturate, or an in-frame timer that does not restart, would clear or declare LOF several frames early or late. A bad hysteresis counter changes `oof_o` one frame off, and the error is seen on the strobe it concerns. The pulse count is compared after every frame, so a missing or extra pulse is caught within two clocks.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef enum logic {ST_IN = 1'b0, ST_OUT = 1'b1} align_st_t;
endpackage

// File: rtl/frm_align_fsm.sv
module frm_align_fsm
  import frm_pkg::*;
#(
  parameter int BAD_N  = 4,
  parameter int GOOD_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic ok,
  output logic oof
);
  localparam int MAXN = (BAD_N > GOOD_N) ? BAD_N : GOOD_N;
  localparam int CW   = $clog2(MAXN + 1);

  align_st_t       st;
  logic [CW-1:0]   run;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_OUT;
      run <= '0;
    end else if (stb) begin
      case (st)
        ST_IN: begin
          if (ok)                           run <= '0;
          else if (run == CW'(BAD_N - 1)) begin
            st  <= ST_OUT;
            run <= '0;
          end else                          run <= run + 1'b1;
        end
        default: begin
          if (!ok)                          run <= '0;
          else if (run == CW'(GOOD_N - 1)) begin
            st  <= ST_IN;
            run <= '0;
          end else                          run <= run + 1'b1;
        end
      endcase
    end
  end

  assign oof = (st == ST_OUT);
endmodule

// File: rtl/frm_lof_timers.sv
module frm_lof_timers #(
  parameter int LIM_TICKS = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic oof,
  output logic lof
);
  localparam int TW = $clog2(LIM_TICKS + 1);
  localparam logic [TW-1:0] LIM = TW'(LIM_TICKS);

  logic [TW-1:0] if_tmr, of_tmr, if_nxt, of_nxt;

  always_comb begin
    if (oof) begin
      if_nxt = '0;
      of_nxt = (of_tmr == LIM) ? of_tmr : of_tmr + 1'b1;
    end else begin
      if_nxt = (if_tmr == LIM) ? if_tmr : if_tmr + 1'b1;
      of_nxt = (if_nxt == LIM) ? '0 : of_tmr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if_tmr <= '0;
      of_tmr <= '0;
      lof    <= 1'b0;
    end else if (tick) begin
      if_tmr <= if_nxt;
      of_tmr <= of_nxt;
      if (of_nxt == LIM)      lof <= 1'b1;
      else if (if_nxt == LIM) lof <= 1'b0;
    end
  end
endmodule

// File: rtl/frm_status_pulse.sv
module frm_status_pulse (
  input  logic clk,
  input  logic rst,
  input  logic oof,
  input  logic lof,
  output logic chg
);
  logic oof_q, lof_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oof_q <= 1'b1;
      lof_q <= 1'b0;
      chg   <= 1'b0;
    end else begin
      oof_q <= oof;
      lof_q <= lof;
      chg   <= (oof != oof_q) || (lof != lof_q);
    end
  end
endmodule

// File: rtl/frm_lof_mon.sv
module frm_lof_mon #(
  parameter int BAD_N     = 4,
  parameter int GOOD_N    = 2,
  parameter int LIM_TICKS = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb_i,
  input  logic frame_ok_i,
  input  logic tick_i,
  output logic oof_o,
  output logic lof_o,
  output logic status_chg_o
);
  logic oof_w, lof_w;

  frm_align_fsm #(.BAD_N(BAD_N), .GOOD_N(GOOD_N)) u_align (
    .clk(clk), .rst(rst), .stb(frame_stb_i), .ok(frame_ok_i), .oof(oof_w)
  );

  frm_lof_timers #(.LIM_TICKS(LIM_TICKS)) u_tmr (
    .clk(clk), .rst(rst), .tick(tick_i), .oof(oof_w), .lof(lof_w)
  );

  frm_status_pulse u_chg (
    .clk(clk), .rst(rst), .oof(oof_w), .lof(lof_w), .chg(status_chg_o)
  );

  assign oof_o = oof_w;
  assign lof_o = lof_w;
endmodule

// File: rtl/frm_lof_mon_chk.sv
module frm_lof_mon_chk (
  input logic clk,
  input logic rst,
  input logic frame_stb_i,
  input logic frame_ok_i,
  input logic tick_i,
  input logic oof_o,
  input logic lof_o,
  input logic status_chg_o
);
  p_reset_state_r1: assert property (@(posedge clk) rst |=> (oof_o && !lof_o));
  p_bad_never_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_stb_i && !frame_ok_i) |=> !$fell(oof_o));
  p_good_never_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (frame_stb_i && frame_ok_i) |=> !$rose(oof_o));
  p_oof_needs_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !frame_stb_i |=> $stable(oof_o));
  p_lof_needs_tick_r5: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(lof_o));
  p_lof_rise_from_oof_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(lof_o) |-> $past(oof_o));
  p_lof_fall_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(lof_o) |-> !$past(oof_o));
  p_pulse_on_change_r8: assert property (@(posedge clk) disable iff (rst)
    ((oof_o != $past(oof_o)) || (lof_o != $past(lof_o))) |=> status_chg_o);
endmodule

bind frm_lof_mon frm_lof_mon_chk u_chk (
  .clk(clk), .rst(rst), .frame_stb_i(frame_stb_i), .frame_ok_i(frame_ok_i),
  .tick_i(tick_i), .oof_o(oof_o), .lof_o(lof_o), .status_chg_o(status_chg_o)
);

// File: tb/frm_lof_mon_tb_top.sv
module frm_lof_mon_tb_top;
  localparam int LIM = 24;

  logic clk = 1'b0, rst = 1'b1;
  logic stb = 1'b0, ok = 1'b0, tick = 1'b0;
  logic oof, lof, chg;

  always #10 clk = ~clk;

  frm_lof_mon dut_i (
    .clk(clk), .rst(rst), .frame_stb_i(stb), .frame_ok_i(ok), .tick_i(tick),
    .oof_o(oof), .lof_o(lof), .status_chg_o(chg)
  );

  typedef struct { logic e_oof; logic e_lof; int e_chg; string tag; } exp_t;
  exp_t exp_q[$];
  event chk_ev;
  int n_chk = 0, n_fail = 0, seen_chg = 0;

  int m_oof = 1, m_lof = 0, m_run = 0, m_if = 0, m_of = 0, m_chg = 0;

  always @(negedge clk) if (!rst && chg) seen_chg++;

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic frame(bit good, string tag);
    exp_t it;
    int prev;
    @(negedge clk); stb = 1'b1; ok = good;
    @(negedge clk); stb = 1'b0; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    #1;
    prev = m_oof;
    if (m_oof == 0) begin
      if (good) m_run = 0;
      else if (m_run == 3) begin m_oof = 1; m_run = 0; end
      else m_run++;
    end else begin
      if (!good) m_run = 0;
      else if (m_run == 1) begin m_oof = 0; m_run = 0; end
      else m_run++;
    end
    if (prev != m_oof) m_chg++;
    prev = m_lof;
    if (m_oof == 1) begin
      m_if = 0;
      if (m_of < LIM) m_of++;
    end else begin
      if (m_if < LIM) m_if++;
      if (m_if == LIM) m_of = 0;
    end
    if (m_of == LIM) m_lof = 1;
    else if (m_if == LIM) m_lof = 0;
    if (prev != m_lof) m_chg++;
    it.e_oof = logic'(m_oof); it.e_lof = logic'(m_lof);
    it.e_chg = m_chg; it.tag = tag;
    exp_q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(chk_ev);
      it = exp_q.pop_front();
      check(it.tag, "oof", int'(oof), int'(it.e_oof));
      check(it.tag, "lof", int'(lof), int'(it.e_lof));
      check({it.tag, "/R8"}, "pulses", seen_chg, it.e_chg);
    end
  end

  initial begin : watchdog
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "oof", int'(oof), 1);
    check("R1", "lof", int'(lof), 0);
    check("R1", "chg", int'(chg), 0);
    // R2: two good frames realign
    frame(1, "R2"); frame(1, "R2");
    // R4: three bad then good keeps alignment, then four bad declares OOF
    frame(0, "R4"); frame(0, "R4"); frame(0, "R4"); frame(1, "R4");
    for (int i = 0; i < 4; i++) frame(0, "R4");
    // R3: good, bad, good stays OOF; then a second good realigns
    frame(1, "R3"); frame(0, "R3"); frame(1, "R3"); frame(1, "R3");
    // R5: OOF bursts separated by short aligned gaps integrate to LOF
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 8; i++) frame(0, "R5");
      frame(1, "R5"); frame(1, "R5"); frame(1, "R5");
    end
    for (int i = 0; i < 6; i++) frame(0, "R5");
    // R7: continuous alignment clears LOF at the limit
    frame(1, "R7");
    for (int i = 0; i < LIM + 3; i++) frame(1, "R7");
    // R6: OOF timer restarted; a shorter burst must not raise LOF
    for (int i = 0; i < LIM - 6; i++) frame(0, "R6");
    frame(1, "R6"); frame(1, "R6");
    for (int i = 0; i < 10; i++) frame(0, "R6");
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule